// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block looks at the first six bytes of every received Ethernet frame, which hold the destination address, and decides whether the frame is kept or discarded. Bytes arrive one per accepted cycle on a byte stream that carries a valid strobe and a start-of-frame marker. The block folds each address byte into a running CRC-32 as it arrives. When the sixth byte is accepted, the block evaluates all match sources at once and issues a registered pass/drop strobe on the next cycle.

Software sets up the filter through a small write-only register port. One register holds four mode bits. A bank of hash registers holds 64, 128 or 256 multicast bins, chosen by a parameter. A set of 48-bit perfect-match slots holds exact addresses. Slot 0 is the station's primary address. A slot whose contents are all zero is disabled. Broadcast and promiscuous traffic bypass every other test. Multicast frames can be accepted wholesale, or screened by the hash bin that the address's CRC selects. Unicast frames need a perfect-slot hit, or a hash hit when the hash-or-perfect mode is set.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset all mode bits, hash bins and slots are zero and `dec_valid` is low, so a unicast frame is dropped and only broadcast passes until software configures the block.
- R2: `dec_valid` is high for exactly one cycle, in the cycle after the sixth address byte is accepted, and never at any other time. Bytes after the sixth byte, up to the next start-of-frame, produce no further decision. `dec_pass` is only high together with `dec_valid`.
- R3: A byte with `rx_sof` high always restarts address capture as byte 0, even while an earlier address is only partly received. Cycles with `rx_valid` low between bytes do not advance capture.
- R4: The all-ones broadcast destination always passes.
- R5: When mode bit 0 (promiscuous) is set, every frame passes.
- R6: When mode bit 1 (accept all multicast) is set, every destination whose first byte has bit 0 set passes without a hash lookup. This mode does not help unicast frames.
- R7: The hash bin is the top HASH_LOG2 bits of the bit-reversed complement of the reflected CRC-32 (initial value all ones, polynomial 0xEDB88320, bytes in arrival order, LSB first) over the six address bytes. Bin b lives in hash register b/32, bit b%32. When mode bit 2 (hash multicast) is set, a multicast frame passes if its bin bit is set.
- R8: A unicast or multicast destination that equals the 48 bits of a nonzero perfect slot passes. A slot holding all zeros never matches.
- R9: When mode bit 3 (hash-or-perfect) is set, a unicast frame also passes on a hash bin hit. Hash hits on unicast frames are ignored while mode bit 3 is clear.
- R10: Every frame that none of R4 to R9 accepts is dropped, whether it is unicast or multicast.
- R11: Register map: the mode register is at 0x00 with bits [3:0] as above. Hash register k is at 0x08+k. Slot s is written at 0x10+2s (bytes 0..3, with byte 0 at bits [7:0]) and at 0x11+2s (bytes 4..5, with byte 4 at bits [7:0] and byte 5 at bits [15:8]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Byte is the first byte of a frame |
| rx_data | input | 8 | Receive byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | Decision strobe, one cycle per frame |
| dec_pass | output | 1 | Frame passes (qualified by dec_valid) |

## Verification
The decision path is tested with a table of destinations. The table holds the primary and a secondary slot address, a near-miss unicast, the all-zero address, broadcast, and several multicast groups. Each destination is paired with a mode word and with a hash bank that is either all set or all clear, which separates mode gating from bin selection. Directed frames then set one computed bin and then every bin but that one. These frames show that the CRC direction, bit reversal and register/bit split are right, and that unicast hashing is gated only by its own mode bit. Variable idle gaps, a restart in the middle of an address, and trailing payload bytes show that exactly one decision is made per frame, and that it comes one cycle after the sixth byte.

// File: rtl/afilt_pkg.sv
`timescale 1ns/1ps
package afilt_pkg;

  localparam int MAC_BYTES = 6;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // bit 0 promisc, bit 1 all multicast, bit 2 hash multicast, bit 3 hash unicast
  typedef struct packed {
    logic hash_uc;
    logic hash_mc;
    logic all_mc;
    logic promisc;
  } afilt_mode_t;

  // one byte of reflected CRC-32, data LSB first
  function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                             input logic [7:0]  data);
    logic [31:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else                c = c >> 1;
    end
    return c;
  endfunction

  // top nbits of bitrev(~crc): index MSB is bit 0 of ~crc
  function automatic logic [7:0] hash_bin(input logic [31:0] crc_final,
                                          input int nbits);
    logic [31:0] v;
    logic [7:0]  idx;
    v   = ~crc_final;
    idx = '0;
    for (int k = 0; k < 8; k++) begin
      if (k < nbits) idx[nbits-1-k] = v[k];
    end
    return idx;
  endfunction

endpackage

// File: rtl/afilt_capture.sv
`timescale 1ns/1ps
module afilt_capture
  import afilt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic [7:0]             in_byte,
  output logic                   addr_done,
  output logic [8*MAC_BYTES-1:0] addr_full,
  output logic [31:0]            crc_full
);
  localparam int CNT_W = $clog2(MAC_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(MAC_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAC_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic [31:0]      crc_q;
  logic [31:0]      crc_base;
  logic [31:0]      crc_nxt;
  logic [7:0]       byte_q [MAC_BYTES];
  logic             take;

  // cnt_q == 0: no frame open; cnt_q == MAC_BYTES: address complete
  assign take     = in_valid && (in_sof || (cnt_q != '0 && cnt_q != FULL_CNT));
  assign pos      = in_sof ? '0 : cnt_q;
  assign crc_base = in_sof ? 32'hFFFF_FFFF : crc_q;
  assign crc_nxt  = crc32_byte(crc_base, in_byte);

  assign addr_done = take && (pos == LAST_POS);
  assign crc_full  = crc_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= 32'hFFFF_FFFF;
    end else if (take) begin
      cnt_q <= pos + CNT_W'(1);
      crc_q <= crc_nxt;
    end
  end

  for (genvar j = 0; j < MAC_BYTES; j++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                            byte_q[j] <= '0;
      else if (take && pos == CNT_W'(j))     byte_q[j] <= in_byte;
    end
    assign addr_full[8*j +: 8] = (take && pos == CNT_W'(j)) ? in_byte : byte_q[j];
  end

endmodule

// File: rtl/afilt_regs.sv
`timescale 1ns/1ps
module afilt_regs
  import afilt_pkg::*;
#(
  parameter int HASH_LOG2 = 6,
  parameter int NUM_SLOTS = 4,
  parameter int CFG_AW    = 6
)(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [CFG_AW-1:0]                   cfg_addr,
  input  logic [31:0]                         cfg_wdata,
  output afilt_mode_t                         mode,
  output logic [(1<<HASH_LOG2)-1:0]           hash_bits,
  output logic [NUM_SLOTS-1:0][8*MAC_BYTES-1:0] slots
);
  localparam int NUM_HREGS = 1 << (HASH_LOG2 - 5);
  localparam int MODE_ADR  = 0;
  localparam int HASH_ADR  = 8;
  localparam int SLOT_ADR  = 16;

  always_ff @(posedge clk) begin
    if (!rst_n)                                      mode <= '0;
    else if (cfg_we && cfg_addr == CFG_AW'(MODE_ADR)) mode <= afilt_mode_t'(cfg_wdata[3:0]);
  end

  // flat hash vector: bin b is hash register b/32, bit b%32
  for (genvar k = 0; k < NUM_HREGS; k++) begin : g_hash
    always_ff @(posedge clk) begin
      if (!rst_n)
        hash_bits[32*k +: 32] <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(HASH_ADR + k))
        hash_bits[32*k +: 32] <= cfg_wdata;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slots[s] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == CFG_AW'(SLOT_ADR + 2*s))     slots[s][31:0]  <= cfg_wdata;
        if (cfg_addr == CFG_AW'(SLOT_ADR + 2*s + 1)) slots[s][47:32] <= cfg_wdata[15:0];
      end
    end
  end

endmodule

// File: rtl/afilt_decide.sv
`timescale 1ns/1ps
module afilt_decide
  import afilt_pkg::*;
#(
  parameter int HASH_LOG2 = 6,
  parameter int NUM_SLOTS = 4
)(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  addr_done,
  input  logic [8*MAC_BYTES-1:0]                addr48,
  input  logic [31:0]                           crc,
  input  afilt_mode_t                           mode,
  input  logic [(1<<HASH_LOG2)-1:0]             hash_bits,
  input  logic [NUM_SLOTS-1:0][8*MAC_BYTES-1:0] slots,
  output logic                                  is_mcast,
  output logic                                  is_bcast,
  output logic                                  hash_hit,
  output logic                                  perfect_hit,
  output logic                                  dec_valid,
  output logic                                  dec_pass
);
  localparam int NUM_BINS = 1 << HASH_LOG2;

  logic [7:0]           bin_idx;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 pass_now;

  assign bin_idx  = hash_bin(crc, HASH_LOG2);
  assign is_mcast = addr48[0];
  assign is_bcast = &addr48;

  always_comb begin
    hash_hit = 1'b0;
    for (int b = 0; b < NUM_BINS; b++) begin
      if (bin_idx == 8'(b)) hash_hit = hash_bits[b];
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_match
    assign slot_hit[s] = (slots[s] != '0) && (slots[s] == addr48);
  end
  assign perfect_hit = |slot_hit;

  always_comb begin
    if (is_bcast || mode.promisc || perfect_hit) pass_now = 1'b1;
    else if (is_mcast)                          pass_now = mode.all_mc || (mode.hash_mc && hash_hit);
    else                                        pass_now = mode.hash_uc && hash_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_pass  <= 1'b0;
    end else begin
      dec_valid <= addr_done;
      dec_pass  <= addr_done && pass_now;
    end
  end

endmodule

// File: rtl/eth_rx_addr_filter.sv
`timescale 1ns/1ps
module eth_rx_addr_filter
  import afilt_pkg::*;
#(
  parameter int HASH_LOG2 = 6,
  parameter int NUM_SLOTS = 4,
  parameter int CFG_AW    = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              dec_valid,
  output logic              dec_pass
);
  logic                                  addr_done;
  logic [8*MAC_BYTES-1:0]                addr_full;
  logic [31:0]                           crc_full;
  afilt_mode_t                           mode;
  logic [(1<<HASH_LOG2)-1:0]             hash_bits;
  logic [NUM_SLOTS-1:0][8*MAC_BYTES-1:0] slots;
  logic                                  is_mcast;
  logic                                  is_bcast;
  logic                                  hash_hit;
  logic                                  perfect_hit;
  logic                                  mode_promisc;
  logic                                  mode_all_mc;

  assign mode_promisc = mode.promisc;
  assign mode_all_mc  = mode.all_mc;

  afilt_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_valid),
    .in_sof    (rx_sof),
    .in_byte   (rx_data),
    .addr_done (addr_done),
    .addr_full (addr_full),
    .crc_full  (crc_full)
  );

  afilt_regs #(
    .HASH_LOG2 (HASH_LOG2),
    .NUM_SLOTS (NUM_SLOTS),
    .CFG_AW    (CFG_AW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mode      (mode),
    .hash_bits (hash_bits),
    .slots     (slots)
  );

  afilt_decide #(
    .HASH_LOG2 (HASH_LOG2),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_done   (addr_done),
    .addr48      (addr_full),
    .crc         (crc_full),
    .mode        (mode),
    .hash_bits   (hash_bits),
    .slots       (slots),
    .is_mcast    (is_mcast),
    .is_bcast    (is_bcast),
    .hash_hit    (hash_hit),
    .perfect_hit (perfect_hit),
    .dec_valid   (dec_valid),
    .dec_pass    (dec_pass)
  );

endmodule

// File: rtl/afilt_chk.sv
`timescale 1ns/1ps
module afilt_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_done,
  input logic dec_valid,
  input logic dec_pass,
  input logic promisc,
  input logic all_mc,
  input logic is_bcast,
  input logic is_mcast,
  input logic perfect_hit
);
  // R2
  done_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> dec_valid);
  // R2
  valid_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(addr_done));
  // R2
  pass_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pass |-> dec_valid);
  // R4
  bcast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && is_bcast) |=> dec_pass);
  // R5
  promisc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && promisc) |=> dec_pass);
  // R6
  all_mc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && is_mcast && all_mc) |=> dec_pass);
  // R8
  perfect_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && perfect_hit) |=> dec_pass);
endmodule

bind eth_rx_addr_filter afilt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_done   (addr_done),
  .dec_valid   (dec_valid),
  .dec_pass    (dec_pass),
  .promisc     (mode_promisc),
  .all_mc      (mode_all_mc),
  .is_bcast    (is_bcast),
  .is_mcast    (is_mcast),
  .perfect_hit (perfect_hit)
);

// File: tb/eth_rx_addr_filter_tb.sv
`timescale 1ns/1ps
module eth_rx_addr_filter_tb;
  localparam int HASH_LOG2 = 6;
  localparam int NUM_SLOTS = 4;
  localparam int CFG_AW    = 6;
  localparam int NH        = 1 << (HASH_LOG2 - 5);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rx_valid, rx_sof;
  logic [7:0]        rx_data;
  logic              cfg_we;
  logic [CFG_AW-1:0] cfg_addr;
  logic [31:0]       cfg_wdata;
  logic              dec_valid, dec_pass;

  int n_chk  = 0;
  int n_fail = 0;
  logic got_v, got_p, early;

  always #2.5 clk = ~clk;

  eth_rx_addr_filter #(.HASH_LOG2(HASH_LOG2), .NUM_SLOTS(NUM_SLOTS), .CFG_AW(CFG_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dec_valid(dec_valid), .dec_pass(dec_pass)
  );

  // address written with byte 0 in the top byte
  typedef struct packed {
    logic [3:0]  mode;
    logic        hfill;
    logic [47:0] addr;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{4'h0, 1'b0, 48'h021122334455, 1'b1, 4'd8},   // R8 primary slot
    '{4'h0, 1'b0, 48'h021122334456, 1'b0, 4'd10},  // R10 near miss
    '{4'h0, 1'b0, 48'hFFFFFFFFFFFF, 1'b1, 4'd4},   // R4 broadcast
    '{4'h0, 1'b0, 48'h010000000001, 1'b0, 4'd10},  // R10 multicast, no mode
    '{4'h1, 1'b0, 48'h021122334456, 1'b1, 4'd5},   // R5 promisc unicast
    '{4'h1, 1'b0, 48'h013355000000, 1'b1, 4'd5},   // R5 promisc multicast
    '{4'h2, 1'b0, 48'h01005E000001, 1'b1, 4'd6},   // R6 all multicast
    '{4'h2, 1'b0, 48'h021122334456, 1'b0, 4'd6},   // R6 no help to unicast
    '{4'h4, 1'b1, 48'h01005E000001, 1'b1, 4'd7},   // R7 bins all set
    '{4'h4, 1'b0, 48'h01005E000001, 1'b0, 4'd7},   // R7 bins all clear
    '{4'h4, 1'b1, 48'h021122334456, 1'b0, 4'd9},   // R9 unicast hash gated
    '{4'h8, 1'b1, 48'h021122334456, 1'b1, 4'd9},   // R9 unicast hash hit
    '{4'h8, 1'b0, 48'h021122334456, 1'b0, 4'd9},   // R9 unicast hash miss
    '{4'h0, 1'b0, 48'h000000000000, 1'b0, 4'd8},   // R8 zero slot never hits
    '{4'h0, 1'b0, 48'h0A0B0C0D0E0F, 1'b1, 4'd8},   // R8 slot 2
    '{4'h8, 1'b1, 48'h0A0B0C0D0E0F, 1'b1, 4'd8}    // R8 slot with hash mode
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CFG_AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R11 slot layout
  task automatic set_slot(input int s, input logic [47:0] a);
    wr(16 + 2*s, {a[23:16], a[31:24], a[39:32], a[47:40]});
    wr(17 + 2*s, {16'h0, a[7:0], a[15:8]});
  endtask

  task automatic fill_hash(input logic [31:0] v);
    for (int k = 0; k < NH; k++) wr(8 + k, v);
  endtask

  task automatic send_addr(input logic [47:0] a, input int gap);
    early = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      early |= dec_valid;
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = a[47-8*i -: 8];
      for (int g = 0; g < gap && i < 5; g++) begin
        @(negedge clk);
        early |= dec_valid;
        rx_valid = 1'b0; rx_sof = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    got_v = dec_valid; got_p = dec_pass;
  endtask

  // bench hash: non-reflected shift form, complement, top bits
  function automatic int ref_bin(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ a[40 - 8*b + i];
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    end
    c = ~c;
    return int'(c >> (32 - HASH_LOG2));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int idx;
    logic [47:0] mc, uc;
    rst_n = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_data = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dec_valid after reset", dec_valid, 0);

    // R1: no configuration, slot 0 empty
    send_addr(48'h021122334455, 0);
    chk("R1 unicast decision strobe", got_v, 1);
    chk("R1 unicast dropped unconfigured", got_p, 0);
    send_addr(48'hFFFFFFFFFFFF, 0);
    chk("R1 broadcast passes unconfigured", got_p, 1);

    set_slot(0, 48'h021122334455);
    set_slot(2, 48'h0A0B0C0D0E0F);

    for (int i = 0; i < 16; i++) begin
      wr(0, {28'h0, VECS[i].mode});
      fill_hash(VECS[i].hfill ? 32'hFFFF_FFFF : 32'h0);
      send_addr(VECS[i].addr, i % 3);
      chk($sformatf("R%0d vec %0d pass", VECS[i].req, i), got_p, VECS[i].exp);
      chk($sformatf("R2 vec %0d strobe", i), {got_v, early}, 2'b10);
    end

    // R2: trailing payload bytes make no second decision
    wr(0, 32'h1);
    send_addr(48'h0A0B0C0D0E0F, 0);
    begin
      logic extra;
      extra = 1'b0;
      for (int t = 0; t < 8; t++) begin
        rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'(t);
        @(negedge clk);
        extra |= dec_valid;
      end
      rx_valid = 1'b0;
      @(negedge clk);
      extra |= dec_valid;
      chk("R2 no decision on payload", extra, 0);
    end

    // R3: restart mid address
    wr(0, 32'h0);
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'h02;
    @(negedge clk); rx_sof = 1'b0; rx_data = 8'h11;
    @(negedge clk); rx_data = 8'h22;
    send_addr(48'h021122334455, 2);
    chk("R3 restart decision strobe", {got_v, early}, 2'b10);
    chk("R3 restart uses new address", got_p, 1);

    // R7/R11: single computed bin
    mc  = 48'h01005E0000FB;
    idx = ref_bin(mc);
    wr(0, 32'h4);
    fill_hash(32'h0);
    wr(8 + idx / 32, 32'h1 << (idx % 32));
    send_addr(mc, 0);
    chk("R7 single bin hit", got_p, 1);
    fill_hash(32'hFFFF_FFFF);
    wr(8 + idx / 32, ~(32'h1 << (idx % 32)));
    send_addr(mc, 1);
    chk("R7 all bins but own", got_p, 0);

    // R10: multicast bin set but only unicast hashing on
    wr(0, 32'h8);
    fill_hash(32'h0);
    wr(8 + idx / 32, 32'h1 << (idx % 32));
    send_addr(mc, 0);
    chk("R10 multicast with unicast-hash mode", got_p, 0);

    // R9: unicast single bin
    uc  = 48'h021122334466;
    idx = ref_bin(uc);
    fill_hash(32'h0);
    wr(8 + idx / 32, 32'h1 << (idx % 32));
    send_addr(uc, 0);
    chk("R9 unicast single bin hit", got_p, 1);
    wr(0, 32'h4);
    send_addr(uc, 0);
    chk("R9 unicast bin ignored without mode", got_p, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule